// File: doc/BRIEF.md
# Configuration Register Slave for a Two-Wire Management Bus

This block lets a host reach a small bank of configuration and status registers over a two-wire management bus (SMBus or I2C style). Both bus lines are sampled with the system clock, which must run at least ten times faster than the bus clock. The slave finds START and STOP conditions on the bus and answers to one fixed 7-bit address, `1010110`. The address byte for a write is therefore `0xAC`, and for a read it is `0xAD`. It drives SDA only by pulling it low, through an output-enable pin.

A dedicated select input is combined with the serial clock. While select is low, the slave takes no part in bus traffic, so the host can talk to other devices on the same wires. The register map mixes two kinds of register. Addresses 0x00 to 0x02 are read-only and mirror status bits supplied by the surrounding logic. Addresses 0x03 to 0x08 are read/write control registers, and their contents are exported as one packed vector. A separate output reports when the bus has been free for a set number of cycles.

Top module: `smb_cfg_slave`

## Requirements
- R1: After reset, the control registers hold 0x77 at 0x03 and 0x04, 0x78 at 0x08 and 0x00 elsewhere; `sda_oe_o` is low and `bus_idle_o` is low. Register 0x03+k appears on `ctrl_o[8k+7:8k]`.
- R2: The slave acknowledges only an address byte whose upper seven bits are 1010110. For any other address it never pulls SDA low until the next START.
- R3: A write is START, 0xAC, register address, data byte, STOP. The slave pulls SDA low during the ninth clock of each of the three bytes, and the addressed control register takes the data byte.
- R4: A read is START, 0xAC, register address, repeated START, 0xAD. The slave then sends the register contents MSB first, on the eight clocks after its acknowledge. Register n (0 to 2) reads `status_i[8n+7:8n]`.
- R5: A write to a read-only address or to an unused address (above 0x08) is acknowledged but changes no register. A read of an unused address returns 0x00.
- R6: While `cs_i` is low, the slave never drives SDA, and bus traffic changes no register.
- R7: A STOP or START that arrives before a byte is complete abandons the transaction, and no register is written. A START begins a fresh address phase.
- R8: `bus_idle_o` rises once SCL and SDA have both been high for BUS_FREE_CYC clock cycles in a row. It falls when either line goes low.
- R9: During the host's acknowledge clock after a read byte, the slave leaves SDA released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 10x the bus clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_i | input | 1 | Select; high lets the slave take part in bus traffic |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level (wired) |
| sda_oe_o | output | 1 | High pulls the data line low |
| status_i | input | 24 | Read-only status bytes for registers 0x00 to 0x02 |
| ctrl_o | output | 48 | Control registers 0x03 to 0x08, packed with 0x03 lowest |
| bus_idle_o | output | 1 | Bus has been free for BUS_FREE_CYC cycles |

## Verification
A wrong internal state in this block shows at the ports in one of two places. It either moves the cycle in which `sda_oe_o` goes high, or it changes which byte lands in `ctrl_o`. A bit counter that is off by one shifts the acknowledge by a whole bus clock, and the host sees this on the ninth clock of the same byte. A corrupt register pointer or shift register shows only when the register is read back, one transaction later. For that reason every write is followed by a read and by a check of the packed control vector.

// File: rtl/smb_cfg_pkg.sv
package smb_cfg_pkg;
    localparam int DW       = 8;
    localparam int RO_REGS  = 3;
    localparam int RW_BASE  = 3;
    localparam int RW_REGS  = 6;
    localparam logic [6:0] DEV_ADDR = 7'b1010110;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_REG,
        ST_WDATA,
        ST_ACK,
        ST_RDATA,
        ST_HACK,
        ST_WAIT
    } smb_state_t;

    // reset value of control register RW_BASE+idx
    function automatic logic [DW-1:0] rw_default(input int idx);
        case (idx)
            0, 1:    return 8'h77;
            5:       return 8'h78;
            default: return 8'h00;
        endcase
    endfunction
endpackage

// File: rtl/smb_sync.sv
module smb_sync #(
    parameter int         W       = 1,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] s1;

    always_ff @(posedge clk) begin
        if (rst) begin
            s1 <= RST_VAL;
            q  <= RST_VAL;
        end else begin
            s1 <= d;
            q  <= s1;
        end
    end
endmodule

// File: rtl/smb_bus_free.sv
module smb_bus_free #(
    parameter int BUS_FREE_CYC = 64
) (
    input  logic clk,
    input  logic rst,
    input  logic scl,
    input  logic sda,
    output logic idle
);
    localparam int CW = $clog2(BUS_FREE_CYC + 1);
    localparam logic [CW-1:0] LIMIT = CW'(BUS_FREE_CYC);

    logic [CW-1:0] run;

    always_ff @(posedge clk) begin
        if (rst)               run <= '0;
        else if (!(scl && sda)) run <= '0;
        else if (run != LIMIT) run <= run + 1'b1;
    end

    assign idle = (run == LIMIT);
endmodule

// File: rtl/smb_regbank.sv
module smb_regbank
    import smb_cfg_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    we,
    input  logic [DW-1:0]           addr,
    input  logic [DW-1:0]           wdata,
    input  logic [RO_REGS*DW-1:0]   status_i,
    output logic [RW_REGS*DW-1:0]   ctrl_o,
    output logic [DW-1:0]           rdata
);
    logic [DW-1:0] regs [RW_REGS];

    for (genvar g = 0; g < RW_REGS; g++) begin : g_rw
        always_ff @(posedge clk) begin
            if (rst)
                regs[g] <= rw_default(g);
            else if (we && addr == DW'(RW_BASE + g))
                regs[g] <= wdata;
        end
        assign ctrl_o[g*DW +: DW] = regs[g];
    end

    always_comb begin
        rdata = '0;
        for (int i = 0; i < RO_REGS; i++)
            if (addr == DW'(i)) rdata = status_i[i*DW +: DW];
        for (int i = 0; i < RW_REGS; i++)
            if (addr == DW'(RW_BASE + i)) rdata = regs[i];
    end
endmodule

// File: rtl/smb_cfg_slave.sv
module smb_cfg_slave
    import smb_cfg_pkg::*;
#(
    parameter int BUS_FREE_CYC = 64
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   cs_i,
    input  logic                   scl_i,
    input  logic                   sda_i,
    output logic                   sda_oe_o,
    input  logic [RO_REGS*DW-1:0]  status_i,
    output logic [RW_REGS*DW-1:0]  ctrl_o,
    output logic                   bus_idle_o
);
    logic cs_s, scl_s, sda_s;
    logic scl_g, scl_p, sda_p;
    logic rise, fall, start_c, stop_c;

    smb_sync #(.W(3), .RST_VAL(3'b011)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   ({cs_i, scl_i, sda_i}),
        .q   ({cs_s, scl_s, sda_s})
    );

    smb_bus_free #(.BUS_FREE_CYC(BUS_FREE_CYC)) u_free (
        .clk  (clk),
        .rst  (rst),
        .scl  (scl_s),
        .sda  (sda_s),
        .idle (bus_idle_o)
    );

    // select gates the bus clock seen by the protocol logic
    assign scl_g = scl_s & cs_s;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_p <= 1'b0;
            sda_p <= 1'b1;
        end else begin
            scl_p <= scl_g;
            sda_p <= sda_s;
        end
    end

    assign rise    =  scl_g & ~scl_p;
    assign fall    = ~scl_g &  scl_p;
    assign start_c =  scl_g &  scl_p &  sda_p & ~sda_s;
    assign stop_c  =  scl_g &  scl_p & ~sda_p &  sda_s;

    smb_state_t    state, ret;
    logic [3:0]    bits;
    logic [DW-1:0] shreg, ptr, tx, wr_data, rd_data;
    logic          wr_en;

    smb_regbank u_regs (
        .clk      (clk),
        .rst      (rst),
        .we       (wr_en),
        .addr     (ptr),
        .wdata    (wr_data),
        .status_i (status_i),
        .ctrl_o   (ctrl_o),
        .rdata    (rd_data)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            ret     <= ST_IDLE;
            bits    <= '0;
            shreg   <= '0;
            ptr     <= '0;
            tx      <= '0;
            wr_en   <= 1'b0;
            wr_data <= '0;
        end else begin
            wr_en <= 1'b0;
            if (!cs_s) begin
                state <= ST_IDLE;
            end else if (start_c) begin
                state <= ST_ADDR;
                bits  <= '0;
            end else if (stop_c) begin
                state <= ST_IDLE;
            end else begin
                case (state)
                    ST_ADDR, ST_REG, ST_WDATA: begin
                        if (rise) begin
                            shreg <= {shreg[DW-2:0], sda_s};
                            bits  <= bits + 4'd1;
                        end else if (fall && bits == 4'd8) begin
                            bits  <= '0;
                            state <= ST_ACK;
                            if (state == ST_ADDR) begin
                                if (shreg[DW-1:1] != DEV_ADDR) begin
                                    state <= ST_WAIT;
                                end else if (shreg[0]) begin
                                    ret <= ST_RDATA;
                                    tx  <= rd_data;
                                end else begin
                                    ret <= ST_REG;
                                end
                            end else if (state == ST_REG) begin
                                ptr <= shreg;
                                ret <= ST_WDATA;
                            end else begin
                                wr_en   <= 1'b1;
                                wr_data <= shreg;
                                ret     <= ST_WAIT;
                            end
                        end
                    end
                    ST_ACK:  if (fall) state <= ret;
                    ST_RDATA: begin
                        if (rise) begin
                            bits <= bits + 4'd1;
                        end else if (fall) begin
                            if (bits == 4'd8) state <= ST_HACK;
                            else              tx <= {tx[DW-2:0], 1'b0};
                        end
                    end
                    ST_HACK: if (fall) state <= ST_WAIT;
                    default: ;
                endcase
            end
        end
    end

    assign sda_oe_o = cs_s && ((state == ST_ACK) ||
                               (state == ST_RDATA && !tx[DW-1]));
endmodule

// File: rtl/smb_cfg_slave_chk.sv
module smb_cfg_slave_chk
    import smb_cfg_pkg::*;
(
    input logic                  clk,
    input logic                  rst,
    input logic                  cs_i,
    input logic                  scl_i,
    input logic                  sda_oe_o,
    input logic [RW_REGS*DW-1:0] ctrl_o,
    input logic                  bus_idle_o
);
    logic [2:0] cs_lo;

    always_ff @(posedge clk) begin
        if (rst)            cs_lo <= '0;
        else if (cs_i)      cs_lo <= '0;
        else if (cs_lo != 3'd4) cs_lo <= cs_lo + 3'd1;
    end

    // R6: deselected slave leaves the line alone
    p_cs_quiet_r6: assert property (@(posedge clk) disable iff (rst)
        (cs_lo == 3'd4) |-> !sda_oe_o);

    // R6: deselected slave keeps its registers
    p_cs_hold_r6: assert property (@(posedge clk) disable iff (rst)
        (cs_lo == 3'd4) |=> $stable(ctrl_o));

    // R2: data line drive changes only while the bus clock is low
    p_oe_scl_low_r2: assert property (@(posedge clk) disable iff (rst)
        !$stable(sda_oe_o) |-> !scl_i);

    // R8: a free bus never coincides with the slave pulling data low
    p_idle_no_drive_r8: assert property (@(posedge clk) disable iff (rst)
        bus_idle_o |-> !sda_oe_o);
endmodule

bind smb_cfg_slave smb_cfg_slave_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .cs_i       (cs_i),
    .scl_i      (scl_i),
    .sda_oe_o   (sda_oe_o),
    .ctrl_o     (ctrl_o),
    .bus_idle_o (bus_idle_o)
);

// File: tb/smb_cfg_slave_bench.sv
module smb_cfg_slave_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cs_i = 1'b1;
    logic        host_scl = 1'b1;
    logic        host_sda = 1'b1;
    logic        sda_i;
    logic        sda_oe_o;
    logic [23:0] status_i = 24'hC3_5A_81;
    logic [47:0] ctrl_o;
    logic        bus_idle_o;
    logic [47:0] exp_ctrl;
    logic        oe_seen;
    logic        done = 1'b0;
    int          n_run = 0;
    int          n_fail = 0;

    always #5 clk = ~clk;

    assign sda_i = host_sda & ~sda_oe_o;

    smb_cfg_slave u_smb_cfg_slave (
        .clk        (clk),
        .rst        (rst),
        .cs_i       (cs_i),
        .scl_i      (host_scl),
        .sda_i      (sda_i),
        .sda_oe_o   (sda_oe_o),
        .status_i   (status_i),
        .ctrl_o     (ctrl_o),
        .bus_idle_o (bus_idle_o)
    );

    always @(posedge clk) if (sda_oe_o) oe_seen <= 1'b1;

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wt(input int n);
        repeat (n) @(negedge clk);
    endtask

    // ---- host bus primitives ----
    task automatic b_start;
        host_sda = 1'b1; wt(4);
        host_scl = 1'b1; wt(8);
        host_sda = 1'b0; wt(8);
        host_scl = 1'b0; wt(2);
    endtask

    task automatic b_stop;
        host_sda = 1'b0; wt(4);
        host_scl = 1'b1; wt(8);
        host_sda = 1'b1; wt(8);
    endtask

    task automatic b_bit(input logic b);
        host_sda = b;    wt(6);
        host_scl = 1'b1; wt(8);
        host_scl = 1'b0; wt(2);
    endtask

    task automatic b_send(input logic [7:0] b, output logic ack);
        for (int i = 7; i >= 0; i--) b_bit(b[i]);
        host_sda = 1'b1; wt(6);
        host_scl = 1'b1; wt(4);
        ack = ~sda_i;    wt(4);
        host_scl = 1'b0; wt(2);
    endtask

    task automatic b_recv(output logic [7:0] d, output logic released);
        d = '0;
        for (int i = 0; i < 8; i++) begin
            host_sda = 1'b1; wt(6);
            host_scl = 1'b1; wt(4);
            d = {d[6:0], sda_i}; wt(4);
            host_scl = 1'b0; wt(2);
        end
        host_sda = 1'b1; wt(6);
        host_scl = 1'b1; wt(4);
        released = ~sda_oe_o; wt(4);
        host_scl = 1'b0; wt(2);
    endtask

    task automatic reg_write(input logic [7:0] abyte, input logic [7:0] ra,
                             input logic [7:0] d, output logic [2:0] acks);
        b_start;
        b_send(abyte, acks[2]);
        b_send(ra, acks[1]);
        b_send(d, acks[0]);
        b_stop;
    endtask

    task automatic reg_read(input logic [7:0] ra, output logic [7:0] d,
                            output logic [2:0] acks, output logic rel);
        b_start;
        b_send(8'hAC, acks[2]);
        b_send(ra, acks[1]);
        b_start;
        b_send(8'hAD, acks[0]);
        b_recv(d, rel);
        b_stop;
    endtask

    // ---- scenarios ----
    task automatic t_reset;
        chk("R1 ctrl defaults", 64'(ctrl_o), 64'h78_00_00_00_77_77);
        chk("R1 no drive", 64'(sda_oe_o), 64'd0);
        chk("R1 idle low after reset", 64'(bus_idle_o), 64'd0);
        wt(80);
        chk("R8 idle after free interval", 64'(bus_idle_o), 64'd1);
    endtask

    task automatic t_write_read;
        logic [2:0] a; logic [7:0] d; logic rel;
        reg_write(8'hAC, 8'h05, 8'hA5, a);
        exp_ctrl[23:16] = 8'hA5;
        chk("R3 three acks", 64'(a), 64'd7);
        chk("R3 reg 0x05 written", 64'(ctrl_o), 64'(exp_ctrl));
        reg_read(8'h05, d, a, rel);
        chk("R4 read acks", 64'(a), 64'd7);
        chk("R4 read 0x05", 64'(d), 64'hA5);
        chk("R9 released on host nack", 64'(rel), 64'd1);
        reg_write(8'hAC, 8'h08, 8'h0C, a);
        exp_ctrl[47:40] = 8'h0C;
        chk("R3 reg 0x08 written", 64'(ctrl_o), 64'(exp_ctrl));
    endtask

    task automatic t_status;
        logic [2:0] a; logic [7:0] d; logic rel;
        reg_read(8'h02, d, a, rel);
        chk("R4 status reg 0x02", 64'(d), 64'hC3);
        reg_read(8'h00, d, a, rel);
        chk("R4 status reg 0x00", 64'(d), 64'h81);
    endtask

    task automatic t_ro_write;
        logic [2:0] a; logic [7:0] d; logic rel;
        reg_write(8'hAC, 8'h01, 8'hFF, a);
        chk("R5 ro write acked", 64'(a), 64'd7);
        chk("R5 ro write no change", 64'(ctrl_o), 64'(exp_ctrl));
        reg_read(8'h01, d, a, rel);
        chk("R5 ro reg still status", 64'(d), 64'h5A);
        reg_write(8'hAC, 8'h30, 8'h3C, a);
        chk("R5 unused write acked", 64'(a), 64'd7);
        chk("R5 unused write no change", 64'(ctrl_o), 64'(exp_ctrl));
        reg_read(8'h30, d, a, rel);
        chk("R5 unused reads zero", 64'(d), 64'h00);
    endtask

    task automatic t_wrong_addr;
        logic [2:0] a;
        oe_seen = 1'b0;
        reg_write(8'hAA, 8'h03, 8'h11, a);
        chk("R2 foreign address no ack", 64'(a), 64'd0);
        chk("R2 never drove", 64'(oe_seen), 64'd0);
        chk("R2 regs unchanged", 64'(ctrl_o), 64'(exp_ctrl));
    endtask

    task automatic t_cs_low;
        logic [2:0] a;
        cs_i = 1'b0; wt(6);
        oe_seen = 1'b0;
        reg_write(8'hAC, 8'h03, 8'h22, a);
        chk("R6 no ack while deselected", 64'(a), 64'd0);
        chk("R6 never drove", 64'(oe_seen), 64'd0);
        chk("R6 regs unchanged", 64'(ctrl_o), 64'(exp_ctrl));
        cs_i = 1'b1; wt(6);
    endtask

    task automatic t_abort;
        logic [2:0] a; logic ak;
        b_start;
        chk("R8 busy during transfer", 64'(bus_idle_o), 64'd0);
        b_send(8'hAC, ak);
        b_send(8'h04, ak);
        for (int i = 0; i < 4; i++) b_bit(1'b0);
        b_stop;
        chk("R7 stop mid-byte no write", 64'(ctrl_o), 64'(exp_ctrl));
        b_start;
        b_send(8'hAC, ak);
        b_send(8'h04, ak);
        for (int i = 0; i < 3; i++) b_bit(1'b1);
        b_start;
        b_send(8'hAC, a[2]);
        b_send(8'h06, a[1]);
        b_send(8'h5E, a[0]);
        b_stop;
        exp_ctrl[31:24] = 8'h5E;
        chk("R7 restart acks", 64'(a), 64'd7);
        chk("R7 restart writes 0x06 only", 64'(ctrl_o), 64'(exp_ctrl));
    endtask

    initial begin
        exp_ctrl = 48'h78_00_00_00_77_77;
        oe_seen = 1'b0;
        wt(4);
        rst = 1'b0;
        wt(1);
        t_reset;
        t_write_read;
        t_status;
        t_ro_write;
        t_wrong_addr;
        t_cs_low;
        t_abort;
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog (all) actual=hung expected=finished");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule